// File: doc/BRIEF.md
# Per-Channel Line Count Interrupt Monitor

This block watches frames on four virtual channels and flags any frame that carries fewer or more lines than the count programmed for that channel. Each channel has its own 16-bit line limit register. Each channel has its own tracker state machine. The tracker reports a 2-bit error code into a sticky field of a 32-bit interrupt status register. The same register captures six single-bit events from the transmit datapath: pixel under-run, a bad short-packet data type, line buffer full, the lanes being in ultra-low-power state, short-packet FIFO full, and an illegal active-lane setting.

Software reads the status word at offset 0x24 and clears bits by writing ones to them. A 32-bit enable mask at offset 0x28 selects which status bits drive the single interrupt output. The line limits live at offsets 0x40, 0x44, 0x48 and 0x4C, for channels 0 to 3. When the parameter `EN_LINE_CHECK` is 0, no trackers are built and status bits [15:8] read as zero.

Each tracker has three states. TRK_IDLE means the channel is outside a frame. TRK_FRAME means it is counting lines. TRK_OVER means the limit has been exceeded and the tracker waits for the frame to end. Transitions: IDLE→FRAME on frame start. FRAME→FRAME (restart) on frame start. FRAME→IDLE on frame end. FRAME→OVER on a line start that arrives when the count already equals the limit. OVER→FRAME on frame start. OVER→IDLE on frame end.

Top module: `lcm_line_monitor`

## Requirements
- R1: After reset, the status word, the enable mask and all line limits read as 0, and `irq` is low.
- R2: The error field of channel c sits at status bits [9+2c:8+2c]. The code 10 (too many lines) is set by the line-start strobe that arrives when the frame's count already equals the limit, and it is visible from the next cycle.
- R3: On a frame-end strobe, the code 01 (too few lines) is set if the frame's line count is below the limit. A count equal to the limit sets no code.
- R4: A frame-start strobe restarts the count at zero and takes priority over frame-end and line-start in the same cycle. Frame-end takes priority over line-start. Line-start strobes outside a frame are ignored.
- R5: Once a field is nonzero, new error codes do not change it until software clears it.
- R6: Writing 1 to a status bit clears it. Writing 0 has no effect. A hardware set and a clear of the same bit in the same cycle leave the bit set; for a field, the new code is stored.
- R7: Event bits latch on a high input: bit 0 under-run, bit 1 bad data type, bit 2 line buffer full, bit 4 short-packet FIFO full.
- R8: Bit 3 latches while the ultra-low-power input is high. Bit 5 latches while `active_lanes` > `max_lanes`.
- R9: Status bits [31:16] and [7:6] always read 0, and no field ever holds 11.
- R10: `irq` is high exactly when some status bit is set and its enable bit (register 0x28) is 1.
- R11: A read request returns data on `rdata` one cycle later. Line limits are writable and readable at 0x40 + 4·c using bits [15:0]. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 8 | Register byte offset |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| vc_fs | input | 4 | Per-channel frame-start strobes |
| vc_ls | input | 4 | Per-channel line-start strobes |
| vc_fe | input | 4 | Per-channel frame-end strobes |
| ev_underrun | input | 1 | Pixel data under-run event |
| ev_bad_dtype | input | 1 | Unsupported or reserved short-packet data type |
| ev_linebuf_full | input | 1 | Line buffer full event |
| ev_gsp_full | input | 1 | Short-packet FIFO full event |
| ulps_active | input | 1 | Lanes in ultra-low-power state |
| active_lanes | input | 3 | Programmed active lane count |
| max_lanes | input | 3 | Configured maximum lane count |
| irq | output | 1 | Interrupt request |

## Verification
Two things can happen to the same status bit in the same cycle: a hardware set and a write-1-to-clear from software. Frame strobes on one channel can also coincide. The bench provokes both on purpose. Directed vectors place a clear write in the same cycle as an event or an error code, and they issue frame-start together with frame-end, and frame-end together with line-start. A long random run then lets clears, reads and strobes overlap freely. Every read and every cycle's `irq` is compared against a bench model that applies the priority rules of R4 and R6 on its own.

// File: rtl/lcm_pkg.sv
package lcm_pkg;
    localparam int NUM_VC   = 4;
    localparam int ADDR_W   = 8;
    localparam int DATA_W   = 32;
    localparam int NUM_EV   = 6;
    localparam int FLD_LSB  = 8;

    localparam logic [ADDR_W-1:0] ADDR_STATUS = 8'h24;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 8'h28;
    localparam logic [ADDR_W-1:0] ADDR_LIM0   = 8'h40;

    localparam logic [1:0] LC_OK   = 2'b00;
    localparam logic [1:0] LC_FEW  = 2'b01;
    localparam logic [1:0] LC_MANY = 2'b10;

    typedef enum logic [1:0] {
        TRK_IDLE  = 2'd0,
        TRK_FRAME = 2'd1,
        TRK_OVER  = 2'd2
    } trk_state_e;

    // Sticky 2-bit field update: a new code is stored only when the field
    // is zero after this cycle's clear (so set beats a same-cycle clear).
    function automatic logic [1:0] next_field(input logic [1:0] cur,
                                              input logic [1:0] clr,
                                              input logic [1:0] code);
        logic [1:0] kept;
        kept = cur & ~clr;
        if (code != LC_OK && kept == LC_OK)
            return code;
        return kept;
    endfunction
endpackage

// File: rtl/lcm_vc_tracker.sv
module lcm_vc_tracker
    import lcm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             frame_start,
    input  logic             line_start,
    input  logic             frame_end,
    input  logic [CNT_W-1:0] limit,
    output logic [1:0]       err_code
);
    trk_state_e       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic             at_limit;

    assign at_limit = (cnt_q == limit);

    // state and counter register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TRK_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (frame_start)
                cnt_q <= '0;
            else if (state_q == TRK_FRAME && !frame_end && line_start && !at_limit)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TRK_IDLE: begin
                if (frame_start) state_d = TRK_FRAME;
            end
            TRK_FRAME: begin
                if (frame_start)                 state_d = TRK_FRAME;
                else if (frame_end)              state_d = TRK_IDLE;
                else if (line_start && at_limit) state_d = TRK_OVER;
            end
            TRK_OVER: begin
                if (frame_start)    state_d = TRK_FRAME;
                else if (frame_end) state_d = TRK_IDLE;
            end
            default: state_d = TRK_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        err_code = LC_OK;
        if (!frame_start && state_q == TRK_FRAME) begin
            if (frame_end) begin
                if (cnt_q < limit) err_code = LC_FEW;
            end else if (line_start && at_limit) begin
                err_code = LC_MANY;
            end
        end
    end
endmodule

// File: rtl/lcm_status_reg.sv
module lcm_status_reg
    import lcm_pkg::*;
#(
    parameter bit EN_LINE_CHECK = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] clr,
    input  logic [NUM_EV-1:0] ev_set,
    input  logic [1:0]        lc_code [NUM_VC],
    output logic [DATA_W-1:0] status
);
    localparam int FLD_W = 2 * NUM_VC;

    logic [NUM_EV-1:0] ev_q;
    logic [1:0]        fld_q [NUM_VC];
    logic [FLD_W-1:0]  fld_flat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ev_q <= '0;
        end else begin
            ev_q <= (ev_q & ~clr[NUM_EV-1:0]) | ev_set;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int c = 0; c < NUM_VC; c++) fld_q[c] <= LC_OK;
        end else begin
            for (int c = 0; c < NUM_VC; c++) begin
                if (EN_LINE_CHECK)
                    fld_q[c] <= next_field(fld_q[c], clr[FLD_LSB+2*c +: 2], lc_code[c]);
                else
                    fld_q[c] <= LC_OK;
            end
        end
    end

    always_comb begin
        for (int c = 0; c < NUM_VC; c++) fld_flat[2*c +: 2] = fld_q[c];
    end

    assign status = {{(DATA_W-FLD_LSB-FLD_W){1'b0}}, fld_flat,
                     {(FLD_LSB-NUM_EV){1'b0}}, ev_q};
endmodule

// File: rtl/lcm_line_monitor.sv
module lcm_line_monitor
    import lcm_pkg::*;
#(
    parameter bit EN_LINE_CHECK = 1'b1,
    parameter int CNT_W         = 16,
    parameter int LANE_W        = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [NUM_VC-1:0] vc_fs,
    input  logic [NUM_VC-1:0] vc_ls,
    input  logic [NUM_VC-1:0] vc_fe,
    input  logic              ev_underrun,
    input  logic              ev_bad_dtype,
    input  logic              ev_linebuf_full,
    input  logic              ev_gsp_full,
    input  logic              ulps_active,
    input  logic [LANE_W-1:0] active_lanes,
    input  logic [LANE_W-1:0] max_lanes,
    output logic              irq
);
    logic [DATA_W-1:0] status_q;
    logic [DATA_W-1:0] mask_q;
    logic [CNT_W-1:0]  lim_q [NUM_VC];
    logic [1:0]        lc_code [NUM_VC];
    logic [DATA_W-1:0] stat_clr;
    logic [NUM_EV-1:0] ev_set;
    logic [DATA_W-1:0] rd_mux;
    logic              lane_bad;

    assign lane_bad = (active_lanes > max_lanes);
    assign ev_set   = {lane_bad, ev_gsp_full, ulps_active,
                       ev_linebuf_full, ev_bad_dtype, ev_underrun};
    assign stat_clr = (wr_en && addr == ADDR_STATUS) ? wdata : '0;

    // configuration registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            for (int c = 0; c < NUM_VC; c++) lim_q[c] <= '0;
        end else if (wr_en) begin
            if (addr == ADDR_MASK) mask_q <= wdata;
            for (int c = 0; c < NUM_VC; c++)
                if (addr == ADDR_LIM0 + ADDR_W'(4*c)) lim_q[c] <= wdata[CNT_W-1:0];
        end
    end

    generate
        if (EN_LINE_CHECK) begin : g_track
            for (genvar c = 0; c < NUM_VC; c++) begin : g_vc
                lcm_vc_tracker #(.CNT_W(CNT_W)) i_trk (
                    .clk         (clk),
                    .rst_n       (rst_n),
                    .frame_start (vc_fs[c]),
                    .line_start  (vc_ls[c]),
                    .frame_end   (vc_fe[c]),
                    .limit       (lim_q[c]),
                    .err_code    (lc_code[c])
                );
            end
        end else begin : g_notrack
            for (genvar c = 0; c < NUM_VC; c++) begin : g_vc
                assign lc_code[c] = LC_OK;
            end
        end
    endgenerate

    lcm_status_reg #(.EN_LINE_CHECK(EN_LINE_CHECK)) i_stat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (stat_clr),
        .ev_set  (ev_set),
        .lc_code (lc_code),
        .status  (status_q)
    );

    always_comb begin
        rd_mux = '0;
        if (addr == ADDR_STATUS) rd_mux = status_q;
        if (addr == ADDR_MASK)   rd_mux = mask_q;
        for (int c = 0; c < NUM_VC; c++)
            if (addr == ADDR_LIM0 + ADDR_W'(4*c))
                rd_mux = {{(DATA_W-CNT_W){1'b0}}, lim_q[c]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= rd_mux;
    end

    assign irq = |(status_q & mask_q);
endmodule

// File: rtl/lcm_checker.sv
module lcm_checker
    import lcm_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [DATA_W-1:0] status_q,
    input logic              ev_underrun,
    input logic              irq
);
    logic stat_wr;
    assign stat_wr = wr_en && (addr == ADDR_STATUS);

    // R9
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == ADDR_STATUS) |=> (rdata[31:16] == 16'h0 && rdata[7:6] == 2'b00));

    // R9
    code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[9:8] != 2'b11 && status_q[11:10] != 2'b11 &&
         status_q[13:12] != 2'b11 && status_q[15:14] != 2'b11));

    // R6
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ev_underrun |=> status_q[0]);

    // R6
    sticky_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[2] && !(stat_wr && wdata[2])) |=> status_q[2]);

    // R5
    field_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q[9:8] != 2'b00 && !(stat_wr && wdata[9:8] != 2'b00)) |=> $stable(status_q[9:8]));

    // R10
    irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(wr_en));
endmodule

bind lcm_line_monitor lcm_checker i_lcm_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (wr_en),
    .rd_en       (rd_en),
    .addr        (addr),
    .wdata       (wdata),
    .rdata       (rdata),
    .status_q    (status_q),
    .ev_underrun (ev_underrun),
    .irq         (irq)
);

// File: tb/test_lcm_line_monitor.sv
module test_lcm_line_monitor;
    import lcm_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0, rd_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic [3:0]  vc_fs = '0, vc_ls = '0, vc_fe = '0;
    logic        ev_underrun = 0, ev_bad_dtype = 0, ev_linebuf_full = 0, ev_gsp_full = 0;
    logic        ulps_active = 0;
    logic [2:0]  active_lanes = 3'd2, max_lanes = 3'd4;
    logic        irq;

    int checks = 0;
    int fails  = 0;

    logic [31:0] exp_status = '0;
    logic [31:0] exp_mask   = '0;
    int          lim [4]    = '{0, 0, 0, 0};
    int          m_st [4]   = '{0, 0, 0, 0};  // 0 idle, 1 frame, 2 over
    int          m_cnt [4]  = '{0, 0, 0, 0};

    always #10 clk = ~clk;  // 50 MHz

    lcm_line_monitor i_lcm_line_monitor (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .vc_fs(vc_fs), .vc_ls(vc_ls), .vc_fe(vc_fe),
        .ev_underrun(ev_underrun), .ev_bad_dtype(ev_bad_dtype),
        .ev_linebuf_full(ev_linebuf_full), .ev_gsp_full(ev_gsp_full),
        .ulps_active(ulps_active), .active_lanes(active_lanes),
        .max_lanes(max_lanes), .irq(irq)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %08h expected %08h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [31:0] read_model(input logic [7:0] a);
        if (a == ADDR_STATUS) return exp_status;
        if (a == ADDR_MASK)   return exp_mask;
        for (int c = 0; c < 4; c++)
            if (a == ADDR_LIM0 + 8'(4*c)) return 32'(lim[c] & 32'hFFFF);
        return 32'h0;
    endfunction

    task automatic model_update(input logic [3:0] fs, input logic [3:0] ls, input logic [3:0] fe,
                                input logic [5:0] ev, input logic [31:0] clr);
        logic [31:0] nxt;
        nxt = '0;
        nxt[5:0] = (exp_status[5:0] & ~clr[5:0]) | ev;
        for (int c = 0; c < 4; c++) begin
            logic [1:0] code, kept;
            code = 2'b00;
            if (fs[c]) begin
                m_st[c] = 1; m_cnt[c] = 0;
            end else if (fe[c] && m_st[c] == 1) begin
                if (m_cnt[c] < lim[c]) code = 2'b01;
                m_st[c] = 0;
            end else if (fe[c] && m_st[c] == 2) begin
                m_st[c] = 0;
            end else if (ls[c] && m_st[c] == 1) begin
                if (m_cnt[c] == lim[c]) begin code = 2'b10; m_st[c] = 2; end
                else m_cnt[c]++;
            end
            kept = exp_status[8+2*c +: 2] & ~clr[8+2*c +: 2];
            nxt[8+2*c +: 2] = (code != 2'b00 && kept == 2'b00) ? code : kept;
        end
        exp_status = nxt;
    endtask

    // ev: 0 underrun, 1 bad dtype, 2 line buffer, 3 ulps, 4 short-packet fifo, 5 lane error
    task automatic step(input logic [3:0] fs, input logic [3:0] ls, input logic [3:0] fe,
                        input logic [5:0] ev, input logic wr, input logic [7:0] a,
                        input logic [31:0] wd, input logic rd, input string tag);
        logic [31:0] exp_rd;
        vc_fs = fs; vc_ls = ls; vc_fe = fe;
        ev_underrun = ev[0]; ev_bad_dtype = ev[1]; ev_linebuf_full = ev[2];
        ulps_active = ev[3]; ev_gsp_full = ev[4];
        active_lanes = ev[5] ? 3'd5 : 3'd2; max_lanes = 3'd4;
        wr_en = wr; rd_en = rd; addr = a; wdata = wd;
        exp_rd = read_model(a);
        model_update(fs, ls, fe, ev, (wr && a == ADDR_STATUS) ? wd : 32'h0);
        if (wr && a == ADDR_MASK) exp_mask = wd;
        for (int c = 0; c < 4; c++)
            if (wr && a == ADDR_LIM0 + 8'(4*c)) lim[c] = int'(wd[15:0]);
        @(negedge clk);
        if (rd) check(tag, rdata, exp_rd);
        check("R10", {31'h0, irq}, {31'h0, |(exp_status & exp_mask)});
        vc_fs = '0; vc_ls = '0; vc_fe = '0; wr_en = 0; rd_en = 0;
        ev_underrun = 0; ev_bad_dtype = 0; ev_linebuf_full = 0; ulps_active = 0; ev_gsp_full = 0;
        active_lanes = 3'd2;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(4'h0, 4'h0, 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "idle");
    endtask
    task automatic rd(input logic [7:0] a, input string tag);
        step(4'h0, 4'h0, 4'h0, 6'h0, 0, a, 32'h0, 1, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        step(4'h0, 4'h0, 4'h0, 6'h0, 1, a, d, 0, "wr");
    endtask
    task automatic frame(input int c, input int n);
        step(4'(1 << c), 4'h0, 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "fs");
        for (int i = 0; i < n; i++) step(4'h0, 4'(1 << c), 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "ls");
        step(4'h0, 4'h0, 4'(1 << c), 6'h0, 0, 8'h0, 32'h0, 0, "fe");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(ADDR_STATUS, "R1");
        rd(ADDR_MASK, "R1");
        rd(ADDR_LIM0 + 8'd12, "R1");

        // R11 limits and unmapped reads
        wr(ADDR_LIM0, 32'd3);
        wr(ADDR_LIM0 + 8'd4, 32'd0);
        wr(ADDR_LIM0 + 8'd8, 32'hFFFF_0002);
        wr(ADDR_LIM0 + 8'd12, 32'd4);
        rd(ADDR_LIM0 + 8'd8, "R11");
        rd(8'h30, "R11");

        // R10 mask gates irq
        step(4'h0, 4'h0, 4'h0, 6'h01, 0, 8'h0, 32'h0, 0, "R7");
        rd(ADDR_STATUS, "R7");
        wr(ADDR_MASK, 32'hFFFF_FFFF);
        rd(ADDR_MASK, "R10");
        wr(ADDR_STATUS, 32'hFFFF_FFFF);

        // R3 exact count, then short frame
        frame(0, 3);
        rd(ADDR_STATUS, "R3");
        frame(0, 2);
        rd(ADDR_STATUS, "R3");
        // R5 later overflow does not overwrite
        frame(0, 5);
        rd(ADDR_STATUS, "R5");
        // R6 writing zero has no effect
        wr(ADDR_STATUS, 32'h0000_0000);
        rd(ADDR_STATUS, "R6");
        wr(ADDR_STATUS, 32'h0000_0100);
        rd(ADDR_STATUS, "R6");

        // R2 overflow on channel 1 with limit 0 and channel 3
        frame(1, 1);
        frame(3, 6);
        rd(ADDR_STATUS, "R2");
        wr(ADDR_STATUS, 32'hFFFF_FFFF);

        // R4 start beats end and line; end beats line; stray lines ignored
        step(4'h4, 4'h0, 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "R4");
        step(4'h4, 4'h4, 4'h4, 6'h0, 0, 8'h0, 32'h0, 0, "R4");
        step(4'h0, 4'h4, 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "R4");
        step(4'h0, 4'h4, 4'h4, 6'h0, 0, 8'h0, 32'h0, 0, "R4");
        step(4'h0, 4'hF, 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "R4");
        rd(ADDR_STATUS, "R4");

        // R6 set beats same-cycle clear, bit and field
        step(4'h0, 4'h0, 4'h0, 6'h04, 1, ADDR_STATUS, 32'h0000_0004, 0, "R6");
        step(4'h1, 4'h0, 4'h0, 6'h0, 0, 8'h0, 32'h0, 0, "R6");
        step(4'h0, 4'h0, 4'h1, 6'h0, 1, ADDR_STATUS, 32'h0000_FF00, 0, "R6");
        rd(ADDR_STATUS, "R6");

        // R7 R8 remaining events
        step(4'h0, 4'h0, 4'h0, 6'h3A, 0, 8'h0, 32'h0, 0, "R8");
        rd(ADDR_STATUS, "R8");
        wr(ADDR_STATUS, 32'hFFFF_FFFF);
        rd(ADDR_STATUS, "R9");

        // R10 partial mask
        wr(ADDR_MASK, 32'h0000_0002);
        step(4'h0, 4'h0, 4'h0, 6'h01, 0, 8'h0, 32'h0, 0, "R10");
        step(4'h0, 4'h0, 4'h0, 6'h02, 0, 8'h0, 32'h0, 0, "R10");
        wr(ADDR_STATUS, 32'h0000_0002);

        // random phase
        void'($urandom(32'd1234));
        for (int c = 0; c < 4; c++) wr(ADDR_LIM0 + 8'(4*c), $urandom_range(0, 5));
        wr(ADDR_MASK, $urandom);
        for (int i = 0; i < 4000; i++) begin
            logic [3:0]  fs, ls, fe;
            logic [5:0]  ev;
            logic        w, r;
            logic [31:0] wd;
            for (int c = 0; c < 4; c++) begin
                fs[c] = ($urandom_range(0, 15) == 0);
                ls[c] = ($urandom_range(0, 2) == 0);
                fe[c] = ($urandom_range(0, 9) == 0);
            end
            for (int b = 0; b < 6; b++) ev[b] = ($urandom_range(0, 24) == 0);
            w  = ($urandom_range(0, 7) == 0);
            r  = ($urandom_range(0, 2) == 0);
            wd = $urandom;
            step(fs, ls, fe, ev, w, ADDR_STATUS, wd, r, "R5");
        end
        idle(2);

        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule